// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two two's-complement operands one bit step at a time using radix-2 Booth recoding. It is split into two parts. One is a datapath that holds the multiplicand, the multiplier/product-low register, an accumulator, a guard bit below the multiplier and an iteration down counter. The other is a control state machine. The controller sees only three status bits: the multiplier's low bit, the guard bit and the counter's last-iteration flag. From these it drives five strobes: load, add, subtract, shift and count-down.

A one-cycle `start` pulse captures both operands. The block then runs one iteration per multiplier bit. An iteration whose recoded digit is zero takes one cycle, which is a shift only. An iteration with a non-zero digit takes two cycles: an add or subtract cycle, then a shift. When the last shift is done, `done` pulses for one cycle. `product` then keeps the signed result until the next accepted start.

Top module: `booth_seq_mult`

## Requirements
- R1: While reset is held and in the cycles after it is released, `done` is 0 and `product` is 0.
- R2: For every pair of operands, including most-negative times most-negative, `product` equals the signed product of `mcand` and `mplier` when `done` is 1.
- R3: The operands are sampled only on the clock edge that accepts `start`. Changing `mcand` or `mplier` afterwards does not alter the result.
- R4: Let k be the number of bit positions i (0 to W-1) where `mplier[i]` differs from `mplier[i-1]`, taking `mplier[-1]` as 0. Count the edge that accepts `start` as edge 1. Then `done` is first seen high after edge W+1+k, which is 5+k for W=4.
- R5: `done` is high for exactly one cycle per multiplication.
- R6: After `done`, `product` keeps its value and `done` stays low until a new `start` is accepted.
- R7: A `start` is accepted only when the block is idle. A `start` raised during a multiplication, or in the cycle in which `done` is high, is ignored. Such a pulse changes neither the result nor the latency, and it launches no second multiplication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a multiplication (accepted when idle) |
| mcand | input | W | Signed multiplicand |
| mplier | input | W | Signed multiplier |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2W | Signed product, held until the next start |

## Verification
The hardest condition to reach from the ports is a `start` that arrives while the controller is in the middle of its sequence. The bench raises a second pulse with different operands a few cycles after launching a multiplier whose recoding mixes one-cycle and two-cycle iterations. It then checks that the result and the edge count still belong to the first operands. It also raises `start` in the exact cycle where `done` is seen. The exhaustive sweep covers the guard-bit case -8 × -8, in which a subtract of the most negative multiplicand would overflow a W-bit accumulator.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_EVAL  = 3'd1,
    ST_SHIFT = 3'd2,
    ST_DONE  = 3'd3
  } booth_state_e;

  typedef struct packed {
    logic load;
    logic add;
    logic sub;
    logic shift;
    logic dec;
  } booth_ctrl_t;

  typedef struct packed {
    logic q_lsb;
    logic guard;
    logic last;
  } booth_stat_t;

endpackage

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  booth_ctrl_t   ctl,
  input  logic [W-1:0]  mcand,
  input  logic [W-1:0]  mplier,
  output booth_stat_t   stat,
  output logic [2*W-1:0] product
);

  localparam int AW = W + 1;
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] ITER = CW'(W);

  logic [AW-1:0] acc_q, acc_d;
  logic [W-1:0]  mq_q, mq_d;
  logic [AW-1:0] mc_q, mc_d;
  logic          grd_q, grd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  assign en = ctl.load | ctl.add | ctl.sub | ctl.shift | ctl.dec;

  always_comb begin
    acc_d = acc_q;
    mq_d  = mq_q;
    mc_d  = mc_q;
    grd_d = grd_q;
    cnt_d = cnt_q;
    if (ctl.load) begin
      acc_d = '0;
      mq_d  = mplier;
      mc_d  = {mcand[W-1], mcand};
      grd_d = 1'b0;
      cnt_d = ITER;
    end else begin
      if (ctl.add)
        acc_d = acc_q + mc_q;
      else if (ctl.sub)
        acc_d = acc_q - mc_q;
      if (ctl.shift)
        {acc_d, mq_d, grd_d} = {acc_q[AW-1], acc_q, mq_q};
      if (ctl.dec)
        cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      mq_q  <= '0;
      mc_q  <= '0;
      grd_q <= 1'b0;
      cnt_q <= '0;
    end else if (en) begin
      acc_q <= acc_d;
      mq_q  <= mq_d;
      mc_q  <= mc_d;
      grd_q <= grd_d;
      cnt_q <= cnt_d;
    end
  end

  assign stat.q_lsb = mq_q[0];
  assign stat.guard = grd_q;
  assign stat.last  = (cnt_q == CW'(1));
  assign product    = {acc_q[W-1:0], mq_q};

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.dec |-> cnt_q != '0);

  // R6
  hold_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(product));

  // R2
  arith_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.add && ctl.sub) && !((ctl.add || ctl.sub) && ctl.shift));

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  booth_stat_t stat,
  output booth_ctrl_t ctl,
  output logic        done
);

  booth_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    ctl  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          ctl.load = 1'b1;
          st_d     = ST_EVAL;
        end
      end
      ST_EVAL: begin
        unique case ({stat.q_lsb, stat.guard})
          2'b10: begin
            ctl.sub = 1'b1;
            st_d    = ST_SHIFT;
          end
          2'b01: begin
            ctl.add = 1'b1;
            st_d    = ST_SHIFT;
          end
          default: begin
            ctl.shift = 1'b1;
            ctl.dec   = 1'b1;
            st_d      = stat.last ? ST_DONE : ST_EVAL;
          end
        endcase
      end
      ST_SHIFT: begin
        ctl.shift = 1'b1;
        ctl.dec   = 1'b1;
        st_d      = stat.last ? ST_DONE : ST_EVAL;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign done = (st_q == ST_DONE);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> !ctl.load);

  // R4
  last_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.shift && stat.last) |=> done);

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           done,
  output logic [2*W-1:0] product
);

  logic [1:0]  rst_sync_q;
  logic        rst_i_n;
  booth_ctrl_t ctl;
  booth_stat_t stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  booth_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_i_n),
    .start (start),
    .stat  (stat),
    .ctl   (ctl),
    .done  (done)
  );

  booth_datapath #(.W(W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .ctl     (ctl),
    .mcand   (mcand),
    .mplier  (mplier),
    .stat    (stat),
    .product (product)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(rst_i_n) |-> !done && product == '0);

endmodule

// File: tb/booth_seq_mult_test.sv
`timescale 1ns/1ps
module booth_seq_mult_test;

  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic           done;
  logic [2*W-1:0] product;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  booth_seq_mult #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mcand(mcand), .mplier(mplier),
    .done(done), .product(product)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int flips(input logic [W-1:0] mp);
    int k = 0;
    for (int i = 0; i < W; i++) begin
      logic prev;
      prev = (i == 0) ? 1'b0 : mp[i-1];
      if (mp[i] != prev) k++;
    end
    return k;
  endfunction

  function automatic int sprod(input logic [W-1:0] a, input logic [W-1:0] b);
    return int'($signed(a)) * int'($signed(b));
  endfunction

  // issue start at a negedge; count edges until done seen at a negedge
  task automatic launch_and_wait(input logic [W-1:0] a, input logic [W-1:0] b,
                                 output int edges);
    mcand = a; mplier = b; start = 1'b1;
    edges = 0;
    for (int n = 0; n < 40; n++) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      start = 1'b0;
      if (done) break;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 product in reset", int'(product), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 product after reset", int'(product), 0);
  endtask

  task automatic t_sweep;
    int edges;
    for (int i = 0; i < (1 << W); i++) begin
      for (int j = 0; j < (1 << W); j++) begin
        launch_and_wait(W'(i), W'(j), edges);
        chk("R2 product", int'($signed(product)), sprod(W'(i), W'(j)));
        chk("R4 latency", edges, W + 1 + flips(W'(j)));
        @(negedge clk);
        chk("R5 done one cycle", int'(done), 0);
      end
    end
  endtask

  task automatic t_corner;
    int edges;
    launch_and_wait(4'b1000, 4'b1000, edges);
    chk("R2 -8*-8", int'($signed(product)), 64);
    @(negedge clk);
    launch_and_wait(4'b0111, 4'b1000, edges);
    chk("R2 7*-8", int'($signed(product)), -56);
    @(negedge clk);
  endtask

  task automatic t_operand_change;
    int edges;
    mcand = 4'd5; mplier = 4'b1101; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; mcand = 4'd2; mplier = 4'd6;
    edges = 1;
    for (int n = 0; n < 40; n++) begin
      if (done) break;
      @(posedge clk); edges++;
      @(negedge clk);
    end
    chk("R3 operands latched", int'($signed(product)), -15);
    chk("R3 latency of latched", edges, W + 1 + flips(4'b1101));
    @(negedge clk);
  endtask

  task automatic t_hold;
    int edges;
    logic [2*W-1:0] snap;
    launch_and_wait(4'b1011, 4'd3, edges);
    snap = product;
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      mcand = W'(n); mplier = W'(n + 3);
      chk("R6 done stays low", int'(done), 0);
    end
    chk("R6 product held", int'(product), int'(snap));
    chk("R6 held value", int'($signed(product)), -15);
  endtask

  task automatic t_busy_start;
    int edges;
    mcand = 4'd3; mplier = 4'b0101; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    @(posedge clk); edges++;
    @(negedge clk);
    mcand = 4'd7; mplier = 4'd7; start = 1'b1;
    @(posedge clk); edges++;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 40; n++) begin
      if (done) break;
      @(posedge clk); edges++;
      @(negedge clk);
    end
    chk("R7 result kept", int'($signed(product)), 15);
    chk("R7 latency kept", edges, W + 1 + flips(4'b0101));
    // start raised during the done cycle must be ignored too
    mcand = 4'd2; mplier = 4'd2; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 12; n++) begin
      chk("R7 no relaunch done", int'(done), 0);
      @(negedge clk);
    end
    chk("R7 no relaunch product", int'($signed(product)), 15);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sweep();
    t_corner();
    t_operand_change();
    t_hold();
    t_busy_start();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule